// File: doc/BRIEF.md
# Cartridge Program-Bank and RAM-Enable Decoder

This block sits on the CPU side of an 8-bit console cartridge. It watches CPU write cycles, captures three 6-bit program-ROM bank numbers and one 8-bit enable byte for each on-board RAM region, and from these drives the program-ROM upper address lines (A13 up to A18) for the 8 KB window the CPU is addressing. Each of the three lower 8 KB windows of the $8000–$FFFF space is switchable. The top window always selects the last bank. A strap input picks whether bank bit 0 lands on A13 (ascending order) or on A18 (reversed order).

RAM regions are enabled by writing a per-region key byte to that region's enable register. A region's chip enable is asserted only while the separately supplied, externally delayed copy of the bus clock is high. The block's read-data contribution is the RAM data for an enabled region and zero for everything else. Register captures happen on the falling edge of the bus clock M2, which the block samples with its own fast clock.

Top module: `cart_prg_bank_ctl`

## Requirements
- R1: A register is written only at a falling edge of `m2` (sampled on `clk`) while `cpu_rnw` is low. A bank register stores data bits 5..0 and ignores bits 7..6.
- R2: For addresses $8000–$9FFF, $A000–$BFFF and $C000–$DFFF, `prg_addr` shows bank register 0, 1 and 2 (written at $7EFA, $7EFB and $7EFC). $E000–$FFFF shows 6'h3F. Addresses below $8000 show 0. `prg_addr` is registered and valid the second `clk` edge after the address is applied.
- R3: With `order_rev` = 0, bank bit k drives `prg_addr[k]`, where `prg_addr[0]` is A13 and `prg_addr[5]` is A18.
- R4: With `order_rev` = 1, bank bit 5 drives `prg_addr[0]` (A13) and bank bit 0 drives `prg_addr[5]` (A18).
- R5: Read cycles, and writes to any address other than the exact bank register addresses (for example $7FFA, $7EFD, $FEFB), leave the bank registers unchanged.
- R6: RAM region 0 ($6000–$67FF) is enabled only while its register at $7EF7 holds 8'hA3. Region 1 ($6800–$6FFF) is enabled only while its register at $7EF8 holds 8'h5C. Any other value disables the region.
- R7: The enable registers are fully decoded. Writes to addresses that differ from $7EF7/$7EF8 in any bit (for example $76F7, $7FF7, $7EF6) have no effect.
- R8: `ram_ce_n[r]` is low only when region r is enabled, the registered address lies inside region r, and `m2_dly` is high. With `m2_dly` low, every RAM enable stays high.
- R9: `cpu_rdata` equals `ram_rdata` while an enabled region is addressed. It is 8'h00 for a disabled region and for unmapped space such as $7000 or $5FFF.
- R10: Holding `m2` static for any length of time does not change any RAM enable.
- R11: Synchronous reset clears all bank registers (switchable windows show 0) and disables all RAM regions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU bus clock; writes latch on its falling edge |
| m2_dly | input | 1 | Externally delayed bus clock that qualifies RAM chip enables |
| cpu_rnw | input | 1 | CPU read (1) / write (0) |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| order_rev | input | 1 | Bank bit order strap: 0 ascending, 1 reversed |
| ram_rdata | input | 8 | Data returned by the cartridge RAM |
| prg_addr | output | 6 | Program-ROM A13..A18 (bit 0 = A13) |
| ram_ce_n | output | 2 | Active-low chip enable per RAM region |
| cpu_rdata | output | 8 | Read data contribution: RAM data or zero |

## Verification
The bench goes after write qualification. A cycle whose R/W rises before `m2` falls must not capture, and a design that latched on address match alone would overwrite bank 0 there. Near-miss and mirror addresses are written for both register kinds. A partially decoded design would alias them and change a bank or unlock RAM. Wrong key values one apart from the real key are also tried. Both bit orders are walked over every window, including the fixed top window and the space below $8000, so a swapped or unreversed line shows up as a wrong A13/A18. The bench also holds `m2_dly` low with a region unlocked, and stalls `m2` for hundreds of cycles. A design that gated RAM from `m2` itself would leak an enable in the first case or drop it in the second.

// File: rtl/cart_prg_pkg.sv
package cart_prg_pkg;
  typedef enum logic {
    ORDER_ASC = 1'b0,
    ORDER_REV = 1'b1
  } bank_order_e;
endpackage

// File: rtl/cart_prg_bank_regs.sv
module cart_prg_bank_regs #(
  parameter int ADDR_W = 16,
  parameter int BANK_W = 6,
  parameter int NUM_BANKS = 3,
  parameter logic [ADDR_W-1:0] REG_BASE = 16'h7EFA
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BANK_W-1:0]           wdata,
  output logic [NUM_BANKS*BANK_W-1:0] bank_flat
);
  // one register per switchable window, exact address compare
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] bank_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q <= '0;
      end else if (wr_stb && (addr == REG_BASE + ADDR_W'(b))) begin
        bank_q <= wdata;
      end
    end
    assign bank_flat[b*BANK_W +: BANK_W] = bank_q;
  end
endmodule

// File: rtl/cart_prg_window_mux.sv
module cart_prg_window_mux
  import cart_prg_pkg::*;
#(
  parameter int BANK_W = 6,
  parameter int NUM_BANKS = 3,
  parameter int WIN_IDX_W = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        rom_sel,
  input  logic [WIN_IDX_W-1:0]        win_idx,
  input  logic                        order_rev,
  input  logic [NUM_BANKS*BANK_W-1:0] bank_flat,
  output logic [BANK_W-1:0]           prg_addr
);
  localparam int NUM_WIN = 1 << WIN_IDX_W;

  logic [BANK_W-1:0] win_bank [NUM_WIN];
  logic [BANK_W-1:0] sel;
  logic [BANK_W-1:0] sel_rev;
  logic [BANK_W-1:0] prg_q;
  bank_order_e       order;

  // windows past the register count are hardwired to the last bank
  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    if (w < NUM_BANKS) begin : g_sw
      assign win_bank[w] = bank_flat[w*BANK_W +: BANK_W];
    end else begin : g_fixed
      assign win_bank[w] = '1;
    end
  end

  assign sel = rom_sel ? win_bank[win_idx] : '0;

  for (genvar k = 0; k < BANK_W; k++) begin : g_rev
    assign sel_rev[k] = sel[BANK_W-1-k];
  end

  assign order = bank_order_e'(order_rev);

  always_ff @(posedge clk) begin
    if (rst) begin
      prg_q <= '0;
    end else begin
      prg_q <= (order == ORDER_REV) ? sel_rev : sel;
    end
  end

  assign prg_addr = prg_q;
endmodule

// File: rtl/cart_ram_gate.sv
module cart_ram_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_RAM = 2,
  parameter int SPAN_LOG2 = 11,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h6000,
  parameter logic [ADDR_W-1:0] EN_REG_BASE = 16'h7EF7,
  parameter logic [NUM_RAM*DATA_W-1:0] RAM_KEYS = {8'h5C, 8'hA3}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_stb,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               m2_dly,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [NUM_RAM-1:0] ram_ce_n,
  output logic [DATA_W-1:0]  cpu_rdata
);
  localparam int PAGE_W = ADDR_W - SPAN_LOG2;
  localparam logic [PAGE_W-1:0] BASE_PAGE = RAM_BASE[ADDR_W-1:SPAN_LOG2];

  logic [NUM_RAM-1:0] armed;
  logic [NUM_RAM-1:0] in_win;
  logic [NUM_RAM-1:0] hit_q;

  for (genvar r = 0; r < NUM_RAM; r++) begin : g_region
    logic [DATA_W-1:0] en_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q <= '0;
      end else if (wr_stb && (addr == EN_REG_BASE + ADDR_W'(r))) begin
        en_q <= wdata;
      end
    end
    assign armed[r]  = (en_q == RAM_KEYS[r*DATA_W +: DATA_W]);
    assign in_win[r] = (addr[ADDR_W-1:SPAN_LOG2] == BASE_PAGE + PAGE_W'(r));
    // chip enable opens only during the delayed clock high phase
    assign ram_ce_n[r] = ~(hit_q[r] & m2_dly);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
    end else begin
      hit_q <= armed & in_win;
    end
  end

  assign cpu_rdata = (|hit_q) ? ram_rdata : '0;
endmodule

// File: rtl/cart_prg_bank_ctl.sv
module cart_prg_bank_ctl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 6,
  parameter int NUM_BANKS = 3,
  parameter int WIN_LOG2 = 13,
  parameter logic [ADDR_W-1:0] BANK_REG_BASE = 16'h7EFA,
  parameter int NUM_RAM = 2,
  parameter int RAM_SPAN_LOG2 = 11,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h6000,
  parameter logic [ADDR_W-1:0] EN_REG_BASE = 16'h7EF7,
  parameter logic [NUM_RAM*DATA_W-1:0] RAM_KEYS = {8'h5C, 8'hA3}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               m2,
  input  logic               m2_dly,
  input  logic               cpu_rnw,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               order_rev,
  input  logic [DATA_W-1:0]  ram_rdata,
  output logic [BANK_W-1:0]  prg_addr,
  output logic [NUM_RAM-1:0] ram_ce_n,
  output logic [DATA_W-1:0]  cpu_rdata
);
  localparam int WIN_IDX_W = ADDR_W - 1 - WIN_LOG2;

  logic m2_q;
  logic wr_stb;
  logic [NUM_BANKS*BANK_W-1:0] bank_flat;

  // bus clock falling edge seen by the sampling clock
  always_ff @(posedge clk) begin
    if (rst) begin
      m2_q <= 1'b0;
    end else begin
      m2_q <= m2;
    end
  end

  assign wr_stb = m2_q & ~m2 & ~cpu_rnw;

  cart_prg_bank_regs #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .REG_BASE(BANK_REG_BASE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(cpu_addr),
    .wdata(cpu_wdata[BANK_W-1:0]), .bank_flat(bank_flat)
  );

  cart_prg_window_mux #(
    .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS), .WIN_IDX_W(WIN_IDX_W)
  ) u_mux (
    .clk(clk), .rst(rst), .rom_sel(cpu_addr[ADDR_W-1]),
    .win_idx(cpu_addr[ADDR_W-2:WIN_LOG2]), .order_rev(order_rev),
    .bank_flat(bank_flat), .prg_addr(prg_addr)
  );

  cart_ram_gate #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_RAM(NUM_RAM), .SPAN_LOG2(RAM_SPAN_LOG2),
    .RAM_BASE(RAM_BASE), .EN_REG_BASE(EN_REG_BASE), .RAM_KEYS(RAM_KEYS)
  ) u_ram (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(cpu_addr), .wdata(cpu_wdata),
    .m2_dly(m2_dly), .ram_rdata(ram_rdata), .ram_ce_n(ram_ce_n), .cpu_rdata(cpu_rdata)
  );
endmodule

// File: rtl/cart_prg_bank_ctl_chk.sv
module cart_prg_bank_ctl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 6,
  parameter int NUM_BANKS = 3,
  parameter int NUM_RAM = 2,
  parameter int RAM_SPAN_LOG2 = 11,
  parameter logic [ADDR_W-1:0] BANK_REG_BASE = 16'h7EFA,
  parameter logic [ADDR_W-1:0] RAM_BASE = 16'h6000
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        m2,
  input logic                        m2_dly,
  input logic                        cpu_rnw,
  input logic [ADDR_W-1:0]           cpu_addr,
  input logic [DATA_W-1:0]           ram_rdata,
  input logic [BANK_W-1:0]           prg_addr,
  input logic [NUM_RAM-1:0]          ram_ce_n,
  input logic [DATA_W-1:0]           cpu_rdata,
  input logic [NUM_BANKS*BANK_W-1:0] bank_flat
);
  localparam int RAM_END = int'(RAM_BASE) + (NUM_RAM << RAM_SPAN_LOG2);
  localparam int BANK_END = int'(BANK_REG_BASE) + NUM_BANKS;

  assert_bank_on_m2_fall_R1: assert property (@(posedge clk) disable iff (rst)
    (bank_flat != $past(bank_flat)) |-> (!$past(cpu_rnw) && $past(m2, 2) && !$past(m2)));

  assert_bank_exact_addr_R5: assert property (@(posedge clk) disable iff (rst)
    (bank_flat != $past(bank_flat)) |->
      (int'($past(cpu_addr)) >= int'(BANK_REG_BASE) && int'($past(cpu_addr)) < BANK_END));

  assert_prg_zero_low_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_addr[ADDR_W-1]) |-> (prg_addr == '0));

  assert_ce_needs_dly_R8: assert property (@(posedge clk) disable iff (rst)
    !(&ram_ce_n) |-> m2_dly);

  assert_ce_single_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~ram_ce_n));

  assert_ce_in_ram_space_R8: assert property (@(posedge clk) disable iff (rst)
    !(&ram_ce_n) |-> (int'($past(cpu_addr)) >= int'(RAM_BASE) && int'($past(cpu_addr)) < RAM_END));

  assert_rdata_source_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_rdata != '0) |-> (cpu_rdata == ram_rdata));
endmodule

bind cart_prg_bank_ctl cart_prg_bank_ctl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
  .NUM_RAM(NUM_RAM), .RAM_SPAN_LOG2(RAM_SPAN_LOG2),
  .BANK_REG_BASE(BANK_REG_BASE), .RAM_BASE(RAM_BASE)
) u_chk (
  .clk(clk), .rst(rst), .m2(m2), .m2_dly(m2_dly), .cpu_rnw(cpu_rnw),
  .cpu_addr(cpu_addr), .ram_rdata(ram_rdata), .prg_addr(prg_addr),
  .ram_ce_n(ram_ce_n), .cpu_rdata(cpu_rdata), .bank_flat(bank_flat)
);

// File: tb/cart_prg_bank_ctl_bench.sv
module cart_prg_bank_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {address[15:0], order_rev, expected prg_addr[5:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {16'h8000, 1'b0, 6'h01}, {16'h9FFF, 1'b0, 6'h01}, {16'hA000, 1'b0, 6'h2C},
    {16'hBFFF, 1'b0, 6'h2C}, {16'hC123, 1'b0, 6'h06}, {16'hE000, 1'b0, 6'h3F},
    {16'hFFFF, 1'b0, 6'h3F}, {16'h7000, 1'b0, 6'h00}, {16'h8000, 1'b1, 6'h20},
    {16'hA000, 1'b1, 6'h0D}, {16'hC000, 1'b1, 6'h18}, {16'hE000, 1'b1, 6'h3F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m2 = 1'b0;
  logic m2_dly = 1'b1;
  logic cpu_rnw = 1'b1;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0] cpu_wdata = 8'h00;
  logic order_rev = 1'b0;
  logic [7:0] ram_rdata = 8'h77;
  logic [5:0] prg_addr;
  logic [1:0] ram_ce_n;
  logic [7:0] cpu_rdata;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cart_prg_bank_ctl u_cart_prg_bank_ctl (
    .clk(clk), .rst(rst), .m2(m2), .m2_dly(m2_dly), .cpu_rnw(cpu_rnw),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .order_rev(order_rev),
    .ram_rdata(ram_rdata), .prg_addr(prg_addr), .ram_ce_n(ram_ce_n),
    .cpu_rdata(cpu_rdata)
  );

  task automatic check(input string req, input int actual, input int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  // one bus cycle: m2 high, then falls; rnw held as given through the fall
  task automatic bus_cycle(input logic [15:0] a, input logic [7:0] d, input logic rnw);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_rnw = rnw; m2 = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    cpu_rnw = 1'b1;
  endtask

  task automatic peek(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11: reset state
    peek(16'h8000); check("R11 bank0 after reset", prg_addr, 6'h00);
    peek(16'hA000); check("R11 bank1 after reset", prg_addr, 6'h00);
    peek(16'h6000); check("R11 ram disabled after reset", ram_ce_n, 2'b11);
    check("R9 rdata zero after reset", cpu_rdata, 8'h00);

    // R1: program banks; high data bits ignored
    bus_cycle(16'h7EFA, 8'hC1, 1'b0);
    bus_cycle(16'h7EFB, 8'h2C, 1'b0);
    bus_cycle(16'h7EFC, 8'h86, 1'b0);

    // R2 R3 R4: table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      order_rev = VEC[i][6];
      peek(VEC[i][22:7]);
      check((VEC[i][6] ? "R4 reversed window" : "R2 R3 ascending window"),
            prg_addr, VEC[i][5:0]);
    end
    order_rev = 1'b0;

    // R1: rnw rises before the m2 fall -> no capture
    @(negedge clk);
    cpu_addr = 16'h7EFA; cpu_wdata = 8'h11; cpu_rnw = 1'b0; m2 = 1'b1;
    repeat (3) @(negedge clk);
    cpu_rnw = 1'b1;
    repeat (2) @(negedge clk);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    peek(16'h8000); check("R1 no capture without write at fall", prg_addr, 6'h01);

    // R5: read cycle and near-miss addresses
    bus_cycle(16'h7EFA, 8'h15, 1'b1);
    bus_cycle(16'h7FFA, 8'h3A, 1'b0);
    bus_cycle(16'h7EFD, 8'h3A, 1'b0);
    bus_cycle(16'hFEFB, 8'h3A, 1'b0);
    bus_cycle(16'h7EF9, 8'h3A, 1'b0);
    peek(16'h8000); check("R5 bank0 unchanged", prg_addr, 6'h01);
    peek(16'hA000); check("R5 bank1 unchanged", prg_addr, 6'h2C);
    peek(16'hC000); check("R5 bank2 unchanged", prg_addr, 6'h06);

    // R6 R9: unlock region 0
    bus_cycle(16'h7EF7, 8'hA3, 1'b0);
    peek(16'h6000); check("R6 region0 enabled", ram_ce_n, 2'b10);
    check("R9 rdata from enabled region", cpu_rdata, 8'h77);
    peek(16'h6800); check("R6 region1 still disabled", ram_ce_n, 2'b11);
    check("R9 rdata zero disabled region", cpu_rdata, 8'h00);

    // R6: wrong key then right key for region 1
    bus_cycle(16'h7EF8, 8'h5D, 1'b0);
    peek(16'h6800); check("R6 wrong key keeps region1 off", ram_ce_n, 2'b11);
    bus_cycle(16'h7EF8, 8'h5C, 1'b0);
    peek(16'h67FF); check("R6 region0 top byte", ram_ce_n, 2'b10);
    peek(16'h6800); check("R6 region1 enabled", ram_ce_n, 2'b01);
    check("R9 rdata region1", cpu_rdata, 8'h77);

    // R8: delayed clock low blocks every enable
    @(negedge clk); m2_dly = 1'b0;
    @(negedge clk); check("R8 m2_dly low blocks ce", ram_ce_n, 2'b11);
    @(negedge clk); m2_dly = 1'b1;
    @(negedge clk); check("R8 m2_dly high restores ce", ram_ce_n, 2'b01);
    peek(16'h7000); check("R8 unmapped no ce", ram_ce_n, 2'b11);
    check("R9 rdata unmapped", cpu_rdata, 8'h00);
    peek(16'h5FFF); check("R8 below ram no ce", ram_ce_n, 2'b11);
    check("R9 rdata below ram", cpu_rdata, 8'h00);

    // R10: stalled m2 keeps regions enabled
    @(negedge clk); m2 = 1'b0;
    repeat (300) @(negedge clk);
    peek(16'h6000); check("R10 m2 stalled low", ram_ce_n, 2'b10);
    @(negedge clk); m2 = 1'b1;
    repeat (300) @(negedge clk);
    peek(16'h6800); check("R10 m2 stalled high", ram_ce_n, 2'b01);
    @(negedge clk); m2 = 1'b0;
    repeat (2) @(negedge clk);

    // R6 R7: disable region0, then mirror writes of the key do nothing
    bus_cycle(16'h7EF7, 8'h00, 1'b0);
    peek(16'h6000); check("R6 region0 disabled by other value", ram_ce_n, 2'b11);
    bus_cycle(16'h76F7, 8'hA3, 1'b0);
    bus_cycle(16'h7FF7, 8'hA3, 1'b0);
    bus_cycle(16'h7EF6, 8'hA3, 1'b0);
    bus_cycle(16'hFEF7, 8'hA3, 1'b0);
    peek(16'h6000); check("R7 mirrors do not unlock", ram_ce_n, 2'b11);
    check("R7 rdata still zero", cpu_rdata, 8'h00);

    // R11: reset mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    peek(16'hA000); check("R11 bank1 cleared", prg_addr, 6'h00);
    peek(16'h6800); check("R11 region1 disabled", ram_ce_n, 2'b11);

    finish_run();
  end
endmodule